// File: doc/BRIEF.md
# PLL Lock Detector with Sticky Loss Flag

This block decides whether a phase-locked loop is locked. It does this by timing the gap between paired reference and feedback edge pulses in a fast detector clock. Either edge may arrive first. The first edge opens a measurement, and the edge from the other side closes it. The gap, counted in detector-clock cycles, is then compared against a tolerance window set by a 3-bit code. Code k allows a gap of up to 2·(k+1) cycles. Fractional-N or spread-spectrum operation should run with the widest code, 7, which allows 16 cycles.

Lock is declared only after 64 in-window comparisons in a row. One comparison outside the window drops lock at once. A separate sticky flag records that lock was lost after it had been reached. The flag stays set after the loop locks again, until a clear strobe removes it. A pin output carries either the live lock state or the sticky flag, chosen by a select input.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset, `lockLive`, `lockSticky` and `lockPin` are 0.
- R2: A comparison passes when the gap between the opening edge and the partner edge is at most 2·(`winCode`+1) detector cycles. This holds whichever side comes first. Edges on both sides in the same cycle give a gap of 0.
- R3: If the partner edge has not arrived when the open measurement has counted 2·(`winCode`+1) cycles, the comparison fails in that cycle. An edge arriving later opens a new measurement.
- R4: `lockLive` rises in the cycle after the 64th consecutive passing comparison, and not before.
- R5: A failing comparison drives `lockLive` low in the next cycle and restarts the count of consecutive passes from zero.
- R6: `lockSticky` sets when `lockLive` goes from 1 to 0. Failing comparisons while `lockLive` is already 0 do not set it.
- R7: `lockSticky` stays set while lock is regained. Only a `stickyClr` pulse clears it, in the following cycle.
- R8: If `stickyClr` is high in the same cycle as a comparison that drops `lockLive`, `lockSticky` ends up set.
- R9: `lockPin` follows `lockLive` when `pinSel` is 0 and `lockSticky` when `pinSel` is 1.
- R10: Code 7 gives the widest window. A gap of 16 cycles passes and a gap of 17 fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refPulse | input | 1 | One-cycle pulse per reference edge |
| fbPulse | input | 1 | One-cycle pulse per feedback edge |
| winCode | input | 3 | Window code k; tolerance 2·(k+1) cycles |
| stickyClr | input | 1 | Clears the sticky flag |
| pinSel | input | 1 | Pin source: 0 live lock, 1 sticky flag |
| lockLive | output | 1 | Current lock state |
| lockSticky | output | 1 | Lock was lost since the last clear |
| lockPin | output | 1 | Selected status for a general-purpose pin |

## Verification
A wrong internal state shows at the ports in one of two ways. A gap counter that is off by one moves the pass/fail boundary, so lock is lost at a gap that should pass, or kept at one that should fail. That is visible one cycle after the comparison. A pass-run counter that is miscounted or not cleared makes lock appear early or late relative to the 64th pass. It also makes lock survive a failure, which shows up at the end of that period. The scoreboard checks both outputs and the pin after every edge pair, so a fault appears within one reference period.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_WAIT_FB  = 2'd1,
    PH_WAIT_REF = 2'd2
  } phaseState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic errStart;
    logic errStep;
    logic runInc;
    logic runClr;
  } ctlStrobes_t;

  // status back from the datapath
  typedef struct packed {
    logic errAtLimit;
    logic runFull;
  } dpStatus_t;

endpackage

// File: rtl/pll_lock_dp.sv
module pll_lock_dp
  import pll_lock_pkg::*;
#(
  parameter int CODE_W   = 3,
  parameter int WIN_STEP = 2,
  parameter int LOCK_RUN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] winCode,
  input  ctlStrobes_t       strb,
  output dpStatus_t         stat
);

  localparam int MAX_LIMIT = WIN_STEP * (2 ** CODE_W);
  localparam int ERR_W     = $clog2(MAX_LIMIT + 1);
  localparam int LIM_W     = ERR_W + 1;
  localparam int RUN_W     = $clog2(LOCK_RUN);

  logic [ERR_W-1:0] errCnt;
  logic [RUN_W-1:0] runCnt;
  logic [LIM_W-1:0] limit;

  // window limit in detector cycles
  always_comb begin
    limit = LIM_W'(WIN_STEP) * (LIM_W'(winCode) + LIM_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCnt <= '0;
    end else if (strb.errStart) begin
      errCnt <= ERR_W'(1);
    end else if (strb.errStep) begin
      errCnt <= errCnt + ERR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (strb.runClr) begin
      runCnt <= '0;
    end else if (strb.runInc && !stat.runFull) begin
      runCnt <= runCnt + RUN_W'(1);
    end
  end

  always_comb begin
    stat.errAtLimit = ({1'b0, errCnt} >= limit);
    stat.runFull    = (runCnt == RUN_W'(LOCK_RUN - 1));
  end

  p_err_bounded_r3 : assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= ERR_W'(MAX_LIMIT));

  p_run_clear_r5 : assert property (@(posedge clk) disable iff (!rstN)
    strb.runClr |=> (runCnt == '0));

endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
  import pll_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        refPulse,
  input  logic        fbPulse,
  input  logic        stickyClr,
  input  dpStatus_t   stat,
  output ctlStrobes_t strb,
  output logic        lockLive,
  output logic        lockSticky
);

  phaseState_t state, stateNxt;
  logic cmpValid, cmpPass;

  // edge pairing
  always_comb begin
    stateNxt      = state;
    strb.errStart = 1'b0;
    strb.errStep  = 1'b0;
    cmpValid      = 1'b0;
    cmpPass       = 1'b0;
    unique case (state)
      PH_IDLE: begin
        if (refPulse && fbPulse) begin
          cmpValid = 1'b1;
          cmpPass  = 1'b1;
        end else if (refPulse) begin
          strb.errStart = 1'b1;
          stateNxt      = PH_WAIT_FB;
        end else if (fbPulse) begin
          strb.errStart = 1'b1;
          stateNxt      = PH_WAIT_REF;
        end
      end
      PH_WAIT_FB: begin
        if (fbPulse) begin
          cmpValid = 1'b1;
          cmpPass  = 1'b1;
          if (refPulse) strb.errStart = 1'b1;
          else          stateNxt      = PH_IDLE;
        end else if (refPulse) begin
          cmpValid      = 1'b1;
          strb.errStart = 1'b1;
        end else if (stat.errAtLimit) begin
          cmpValid = 1'b1;
          stateNxt = PH_IDLE;
        end else begin
          strb.errStep = 1'b1;
        end
      end
      PH_WAIT_REF: begin
        if (refPulse) begin
          cmpValid = 1'b1;
          cmpPass  = 1'b1;
          if (fbPulse) strb.errStart = 1'b1;
          else         stateNxt      = PH_IDLE;
        end else if (fbPulse) begin
          cmpValid      = 1'b1;
          strb.errStart = 1'b1;
        end else if (stat.errAtLimit) begin
          cmpValid = 1'b1;
          stateNxt = PH_IDLE;
        end else begin
          strb.errStep = 1'b1;
        end
      end
      default: stateNxt = PH_IDLE;
    endcase
    strb.runInc = cmpValid && cmpPass;
    strb.runClr = cmpValid && !cmpPass;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= stateNxt;
  end

  // lock and sticky tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockLive   <= 1'b0;
      lockSticky <= 1'b0;
    end else begin
      if (strb.runClr) begin
        lockLive <= 1'b0;
      end else if (strb.runInc && stat.runFull) begin
        lockLive <= 1'b1;
      end
      if (strb.runClr && lockLive) begin
        lockSticky <= 1'b1;
      end else if (stickyClr) begin
        lockSticky <= 1'b0;
      end
    end
  end

  p_strobe_excl_r2 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.errStart, strb.errStep}));

  p_lock_after_run_r4 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockLive) |-> $past(stat.runFull));

  p_sticky_on_fall_r6 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockLive) |-> lockSticky);

  p_sticky_set_cause_r6 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockSticky) |-> $fell(lockLive));

  p_sticky_clear_cause_r7 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockSticky) |-> $past(stickyClr));

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import pll_lock_pkg::*;
#(
  parameter int CODE_W   = 3,
  parameter int WIN_STEP = 2,
  parameter int LOCK_RUN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refPulse,
  input  logic              fbPulse,
  input  logic [CODE_W-1:0] winCode,
  input  logic              stickyClr,
  input  logic              pinSel,
  output logic              lockLive,
  output logic              lockSticky,
  output logic              lockPin
);

  ctlStrobes_t strb;
  dpStatus_t   stat;

  pll_lock_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .refPulse   (refPulse),
    .fbPulse    (fbPulse),
    .stickyClr  (stickyClr),
    .stat       (stat),
    .strb       (strb),
    .lockLive   (lockLive),
    .lockSticky (lockSticky)
  );

  pll_lock_dp #(
    .CODE_W   (CODE_W),
    .WIN_STEP (WIN_STEP),
    .LOCK_RUN (LOCK_RUN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .winCode (winCode),
    .strb    (strb),
    .stat    (stat)
  );

  assign lockPin = pinSel ? lockSticky : lockLive;

  p_pin_route_r9 : assert property (@(posedge clk) disable iff (!rstN)
    lockPin == (pinSel ? lockSticky : lockLive));

endmodule

// File: tb/tb_pll_lock_detect.sv
module tb_pll_lock_detect;

  localparam int PERIOD = 40;
  localparam int NONE   = 1000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refPulse = 1'b0, fbPulse = 1'b0, stickyClr = 1'b0, pinSel = 1'b0;
  logic [2:0] winCode = 3'd0;
  logic       lockLive, lockSticky, lockPin;

  pll_lock_detect dut (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .fbPulse(fbPulse),
    .winCode(winCode), .stickyClr(stickyClr), .pinSel(pinSel),
    .lockLive(lockLive), .lockSticky(lockSticky), .lockPin(lockPin)
  );

  always #4 clk = ~clk;

  typedef struct {
    string req;
    bit    live;
    bit    sticky;
    bit    pin;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  int run = 0;
  bit mLive = 1'b0;
  bit mSticky = 1'b0;

  task automatic pushExp(input string req);
    exp_t e;
    e.req = req; e.live = mLive; e.sticky = mSticky;
    e.pin = pinSel ? mSticky : mLive;
    q.push_back(e);
  endtask

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (lockLive !== e.live || lockSticky !== e.sticky || lockPin !== e.pin) begin
          errors++;
          $display("FAIL %s: live/sticky/pin actual %b%b%b expected %b%b%b",
                   e.req, lockLive, lockSticky, lockPin, e.live, e.sticky, e.pin);
        end
      end
    end
  end

  // driver: one edge pair per period, optional clear at cycle clrAt
  task automatic sendPair(input int d, input bit fbFirst, input int clrAt, input string req);
    int lim;
    bit pass, wasLive;
    lim = 2 * (int'(winCode) + 1);
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      refPulse  = fbFirst ? (i == d) : (i == 0);
      fbPulse   = fbFirst ? (i == 0) : (i == d);
      stickyClr = (i == clrAt);
    end
    @(negedge clk);
    refPulse = 1'b0; fbPulse = 1'b0; stickyClr = 1'b0;
    pass = (d <= lim);
    wasLive = mLive;
    if (pass) begin
      run++;
      if (run >= 64) mLive = 1'b1;
      if (clrAt >= 0) mSticky = 1'b0;
    end else begin
      if (clrAt >= 0 && clrAt < lim) mSticky = 1'b0;
      if (mLive) mSticky = 1'b1;
      mLive = 1'b0;
      run = 0;
      if (clrAt > lim) mSticky = 1'b0;
      if (clrAt == lim && !wasLive) mSticky = 1'b0;
    end
    pushExp(req);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    pushExp("R1");
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    pushExp("R1");
    // missing partner while unlocked: no sticky (R3, R6)
    sendPair(NONE, 1'b0, -1, "R6");
    // 64 coincident pairs reach lock (R4)
    for (int n = 0; n < 64; n++) sendPair(0, 1'b0, -1, "R4");
    // boundary gaps at code 0, limit 2 (R2)
    sendPair(2, 1'b0, -1, "R2");
    sendPair(1, 1'b1, -1, "R2");
    // one cycle beyond drops lock and sets sticky (R5)
    sendPair(3, 1'b0, -1, "R5");
    // relock with sticky held (R7)
    for (int n = 0; n < 64; n++) sendPair(0, 1'b0, -1, "R7");
    pinSel = 1'b1;
    @(negedge clk);
    pushExp("R9");
    repeat (2) @(negedge clk);
    pinSel = 1'b0;
    // clear strobe during a passing period (R7)
    sendPair(0, 1'b0, 5, "R7");
    // widest window (R10)
    winCode = 3'd7;
    sendPair(16, 1'b0, -1, "R10");
    sendPair(16, 1'b1, -1, "R10");
    // loss of lock and clear in the same cycle (R8)
    sendPair(17, 1'b0, 16, "R8");
    // clear while unlocked, then a fail that must not set it (R6)
    sendPair(NONE, 1'b0, 3, "R6");
    // code 2, limit 6, feedback first
    winCode = 3'd2;
    for (int n = 0; n < 64; n++) sendPair(0, 1'b1, -1, "R4");
    sendPair(6, 1'b1, -1, "R2");
    sendPair(7, 1'b1, -1, "R3");
    pinSel = 1'b1;
    sendPair(0, 1'b0, -1, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule